// File: doc/BRIEF.md
# Strobe-Order Refresh Detector with Internal Row Counter

This block sits on the memory-device side of a DRAM interface. It watches two active-low strobes, a row strobe and a column strobe, sampling them on the system clock. The order in which the two strobes fall selects the operation.

When the row strobe falls first, the cycle is a normal access. The block captures the row address on the bus when the row strobe falls. It captures the column address when the column strobe falls. It then reports both on a one-cycle access pulse.

When the column strobe falls first, the cycle is a refresh request. The block ignores the address bus in this case. The row to refresh comes from an internal counter, which advances by one after every refresh and wraps at the last row. In both cases the operation closes only when both strobes are high again. A new operation can start only after that.

Top module: `cbr_refresh_detector`

## Requirements
- R1: While reset is held low, both output pulses stay low. After reset the refresh counter is zero, so the first refresh reports row 0.
- R2: In a normal access, the row is the address sampled on the clock edge where the row strobe is first seen low while the column strobe is still high. Later changes of the address do not alter it.
- R3: For a normal access, accessValid is high for exactly one cycle, starting on the edge where the column strobe is first seen low. accessRow carries the latched row and accessCol carries the address sampled on that edge.
- R4: A refresh starts when the column strobe is seen low while the row strobe is high. It fires when the row strobe is later seen low while the column strobe stays low. refreshValid is then high for one cycle, and refreshRow carries the counter value. The address bus has no effect on a refresh.
- R5: The counter advances by one after each refresh. It wraps from ROW_COUNT-1 (8191 by default) to 0.
- R6: If both strobes are first seen low on the same edge, the operation is a normal access. Row and column are both taken from that edge's address.
- R7: Once an access has been reported, further column strobe toggles while the row strobe stays low produce no more access pulses.
- R8: After an operation completes, nothing new starts until both strobes have been seen high together. A second row strobe fall, with the column strobe held low, produces no refresh and no access.
- R9: An open sequence is abandoned with no output if its first strobe rises before the second strobe falls. An abandoned refresh leaves the counter unchanged.
- R10: accessValid and refreshValid are never high in the same cycle. Neither pulse lasts two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and address sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| addr | input | ADDR_W | Multiplexed row/column address bus |
| accessValid | output | 1 | One-cycle pulse reporting a completed normal access |
| accessRow | output | ADDR_W | Row captured for the reported access |
| accessCol | output | ADDR_W | Column captured for the reported access |
| refreshValid | output | 1 | One-cycle pulse reporting a refresh |
| refreshRow | output | $clog2(ROW_COUNT) | Row index refreshed, taken from the internal counter |

## Verification
The checks assume the strobes and the address are synchronous to the clock and hold steady around each rising edge. They also assume that a strobe fall is seen as a single level change between two samples, with no glitches in between. The bench changes every input only on the falling clock edge, so each rising edge sees settled values. Each strobe edge spans at least one full cycle.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic latchRow;    // capture bus as row address
    logic rowBypass;   // use bus directly as row (simultaneous fall)
    logic fireAccess;  // report access with column from bus
    logic fireRefresh; // report refresh and advance the counter
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ROW_OPEN  = 2'd1,
    ST_CBR_ARMED = 2'd2,
    ST_DRAIN     = 2'd3
  } seqState_t;

endpackage

// File: rtl/cbr_strobe_ctrl.sv
`timescale 1ns/1ps
module cbr_strobe_ctrl
  import cbr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rasN,
  input  logic         casN,
  output ctrlStrobes_t strobes
);

  logic      rasPrev;
  logic      casPrev;
  seqState_t state;
  seqState_t stateNext;
  logic      rasFall;
  logic      casFall;
  logic      bothHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPrev <= 1'b1;
      casPrev <= 1'b1;
      state   <= ST_IDLE;
    end else begin
      rasPrev <= rasN;
      casPrev <= casN;
      state   <= stateNext;
    end
  end

  assign rasFall  = rasPrev & ~rasN;
  assign casFall  = casPrev & ~casN;
  assign bothHigh = rasN & casN;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (rasFall && casFall) begin
          strobes.rowBypass  = 1'b1;
          strobes.fireAccess = 1'b1;
          stateNext          = ST_DRAIN;
        end else if (rasFall) begin
          strobes.latchRow = 1'b1;
          stateNext        = ST_ROW_OPEN;
        end else if (casFall) begin
          stateNext = ST_CBR_ARMED;
        end
      end
      ST_ROW_OPEN: begin
        if (rasN) begin
          stateNext = bothHigh ? ST_IDLE : ST_DRAIN;
        end else if (casFall) begin
          strobes.fireAccess = 1'b1;
          stateNext          = ST_DRAIN;
        end
      end
      ST_CBR_ARMED: begin
        if (casN) begin
          stateNext = bothHigh ? ST_IDLE : ST_DRAIN;
        end else if (rasFall) begin
          strobes.fireRefresh = 1'b1;
          stateNext           = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (bothHigh) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cbr_addr_path.sv
`timescale 1ns/1ps
module cbr_addr_path
  import cbr_pkg::*;
#(
  parameter int ROW_COUNT = 8192,
  parameter int ADDR_W    = 13
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            addr,
  input  ctrlStrobes_t                 strobes,
  output logic                         accessValid,
  output logic [ADDR_W-1:0]            accessRow,
  output logic [ADDR_W-1:0]            accessCol,
  output logic                         refreshValid,
  output logic [$clog2(ROW_COUNT)-1:0] refreshRow
);

  localparam int ROW_W = $clog2(ROW_COUNT);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROW_COUNT - 1);

  logic [ADDR_W-1:0] rowHeld;
  logic [ROW_W-1:0]  refCounter;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowHeld      <= '0;
      refCounter   <= '0;
      accessValid  <= 1'b0;
      accessRow    <= '0;
      accessCol    <= '0;
      refreshValid <= 1'b0;
      refreshRow   <= '0;
    end else begin
      accessValid  <= strobes.fireAccess;
      refreshValid <= strobes.fireRefresh;
      if (strobes.latchRow) rowHeld <= addr;
      if (strobes.fireAccess) begin
        accessRow <= strobes.rowBypass ? addr : rowHeld;
        accessCol <= addr;
      end
      if (strobes.fireRefresh) begin
        refreshRow <= refCounter;
        refCounter <= (refCounter == LAST_ROW) ? '0 : refCounter + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cbr_refresh_detector.sv
`timescale 1ns/1ps
module cbr_refresh_detector
  import cbr_pkg::*;
#(
  parameter int ROW_COUNT = 8192,
  parameter int ADDR_W    = 13
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rasN,
  input  logic                         casN,
  input  logic [ADDR_W-1:0]            addr,
  output logic                         accessValid,
  output logic [ADDR_W-1:0]            accessRow,
  output logic [ADDR_W-1:0]            accessCol,
  output logic                         refreshValid,
  output logic [$clog2(ROW_COUNT)-1:0] refreshRow
);

  ctrlStrobes_t strobes;

  cbr_strobe_ctrl ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .rasN    (rasN),
    .casN    (casN),
    .strobes (strobes)
  );

  cbr_addr_path #(
    .ROW_COUNT (ROW_COUNT),
    .ADDR_W    (ADDR_W)
  ) pathInst (
    .clk          (clk),
    .rstN         (rstN),
    .addr         (addr),
    .strobes      (strobes),
    .accessValid  (accessValid),
    .accessRow    (accessRow),
    .accessCol    (accessCol),
    .refreshValid (refreshValid),
    .refreshRow   (refreshRow)
  );

endmodule

// File: rtl/cbr_refresh_detector_chk.sv
`timescale 1ns/1ps
module cbr_refresh_detector_chk #(
  parameter int ROW_COUNT = 8192,
  parameter int ADDR_W    = 13
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         rasN,
  input logic                         casN,
  input logic [ADDR_W-1:0]            addr,
  input logic                         accessValid,
  input logic [ADDR_W-1:0]            accessRow,
  input logic [ADDR_W-1:0]            accessCol,
  input logic                         refreshValid,
  input logic [$clog2(ROW_COUNT)-1:0] refreshRow
);

  localparam int ROW_W = $clog2(ROW_COUNT);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROW_COUNT - 1);

  logic             seenRefresh;
  logic [ROW_W-1:0] lastRefRow;
  logic [ROW_W-1:0] nextRefRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenRefresh <= 1'b0;
      lastRefRow  <= '0;
    end else if (refreshValid) begin
      seenRefresh <= 1'b1;
      lastRefRow  <= refreshRow;
    end
  end

  assign nextRefRow = (lastRefRow == LAST_ROW) ? '0 : lastRefRow + 1'b1;

  // R1
  first_refresh_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshValid && !seenRefresh) |-> (refreshRow == '0));

  // R5
  counter_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshValid && seenRefresh) |-> (refreshRow == nextRefRow));

  // R10
  exclusive_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accessValid && refreshValid));

  // R10
  access_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessValid |=> !accessValid);

  // R10
  refresh_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshValid |=> !refreshValid);

  // R3
  access_needs_row_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessValid) |-> (!$past(rasN) && !$past(casN)));

  // R4
  refresh_needs_both_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshValid) |-> (!$past(rasN) && !$past(casN)));

endmodule

bind cbr_refresh_detector cbr_refresh_detector_chk #(
  .ROW_COUNT (ROW_COUNT),
  .ADDR_W    (ADDR_W)
) chkInst (
  .clk          (clk),
  .rstN         (rstN),
  .rasN         (rasN),
  .casN         (casN),
  .addr         (addr),
  .accessValid  (accessValid),
  .accessRow    (accessRow),
  .accessCol    (accessCol),
  .refreshValid (refreshValid),
  .refreshRow   (refreshRow)
);

// File: tb/tb_cbr_refresh_detector.sv
`timescale 1ns/1ps
module tb_cbr_refresh_detector;

  localparam int ROW_COUNT = 8192;
  localparam int ADDR_W    = 13;
  localparam int ROW_W     = $clog2(ROW_COUNT);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rasN = 1'b1;
  logic              casN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              accessValid;
  logic [ADDR_W-1:0] accessRow;
  logic [ADDR_W-1:0] accessCol;
  logic              refreshValid;
  logic [ROW_W-1:0]  refreshRow;

  int tests  = 0;
  int failed = 0;
  bit finished = 1'b0;
  int expRef = 0;

  int    qKind[$];
  int    qRow[$];
  int    qCol[$];
  string qTag[$];

  always #2 clk = ~clk;

  cbr_refresh_detector #(.ROW_COUNT(ROW_COUNT), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .addr(addr),
    .accessValid(accessValid), .accessRow(accessRow), .accessCol(accessCol),
    .refreshValid(refreshValid), .refreshRow(refreshRow)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int kind, input int row, input int col, input string tag);
    qKind.push_back(kind);
    qRow.push_back(row);
    qCol.push_back(col);
    qTag.push_back(tag);
  endtask

  task automatic release_all();
    rasN = 1'b1; casN = 1'b1; addr = ADDR_W'($urandom); step(1);
  endtask

  task automatic doAccess(input int row, input int col, input string tag);
    addr = ADDR_W'(row); rasN = 1'b0; step(1);
    addr = ADDR_W'(col); casN = 1'b0; push(0, row, col, tag); step(1);
    addr = ADDR_W'($urandom); step(1);
    release_all();
  endtask

  task automatic doRefresh(input string tag);
    addr = ADDR_W'($urandom); casN = 1'b0; step(1);
    addr = ADDR_W'($urandom); rasN = 1'b0; push(1, expRef, 0, tag);
    expRef = (expRef == ROW_COUNT - 1) ? 0 : expRef + 1;
    step(2);
    release_all();
  endtask

  task automatic checkDrained(input string tag);
    step(2);
    tests++;
    if (qKind.size() != 0) begin
      failed++;
      $display("FAIL %s: %0d expected pulses outstanding, expected 0", tag, qKind.size());
      qKind.delete(); qRow.delete(); qCol.delete(); qTag.delete();
    end
  endtask

  // Monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (accessValid && refreshValid) begin
        tests++; failed++;
        $display("FAIL R10: access=1 refresh=1, expected at most one");
      end
      if (accessValid) begin
        tests++;
        if (qKind.size() == 0) begin
          failed++;
          $display("FAIL R7/R8/R9: unexpected access row=%0d col=%0d, expected none", accessRow, accessCol);
        end else begin
          if (qKind[0] != 0 || int'(accessRow) != qRow[0] || int'(accessCol) != qCol[0]) begin
            failed++;
            $display("FAIL %s: access row=%0d col=%0d, expected kind=%0d row=%0d col=%0d",
                     qTag[0], accessRow, accessCol, qKind[0], qRow[0], qCol[0]);
          end
          void'(qKind.pop_front()); void'(qRow.pop_front());
          void'(qCol.pop_front());  void'(qTag.pop_front());
        end
      end
      if (refreshValid) begin
        tests++;
        if (qKind.size() == 0) begin
          failed++;
          $display("FAIL R8/R9: unexpected refresh row=%0d, expected none", refreshRow);
        end else begin
          if (qKind[0] != 1 || int'(refreshRow) != qRow[0]) begin
            failed++;
            $display("FAIL %s: refresh row=%0d, expected kind=%0d row=%0d",
                     qTag[0], refreshRow, qKind[0], qRow[0]);
          end
          void'(qKind.pop_front()); void'(qRow.pop_front());
          void'(qCol.pop_front());  void'(qTag.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      tests++; failed++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: quiet during reset
    tests++;
    if (accessValid || refreshValid) begin
      failed++;
      $display("FAIL R1: access=%0b refresh=%0b in reset, expected 0 0", accessValid, refreshValid);
    end
    rstN = 1'b1; step(2);
    tests++;
    if (accessValid || refreshValid) begin
      failed++;
      $display("FAIL R1: access=%0b refresh=%0b after reset, expected 0 0", accessValid, refreshValid);
    end

    doRefresh("R1");
    doAccess(13'h0123, 13'h1ABC, "R2");
    doAccess(13'h1FFF, 13'h0000, "R3");
    doAccess(13'h0A5A, 13'h15A5, "R3");
    doRefresh("R4");
    doRefresh("R4");
    checkDrained("R4");

    // R6: simultaneous fall
    addr = 13'h0777; rasN = 1'b0; casN = 1'b0; push(0, 13'h0777, 13'h0777, "R6");
    step(1); addr = 13'h1111; step(1); release_all();
    checkDrained("R6");

    // R7: column strobe toggles after an access
    addr = 13'h0042; rasN = 1'b0; step(1);
    addr = 13'h0099; casN = 1'b0; push(0, 13'h0042, 13'h0099, "R7"); step(1);
    casN = 1'b1; step(1); addr = 13'h0333; casN = 1'b0; step(1);
    casN = 1'b1; step(1); casN = 1'b0; step(1);
    release_all();
    checkDrained("R7");

    // R8: after a refresh, row strobe pulses with column strobe held low
    doRefresh("R8");
    casN = 1'b0; step(1); rasN = 1'b0; push(1, expRef, 0, "R8");
    expRef = (expRef == ROW_COUNT - 1) ? 0 : expRef + 1;
    step(1); rasN = 1'b1; step(1); rasN = 1'b0; step(2);
    release_all();
    checkDrained("R8");

    // R8: after an access, row strobe pulses with column strobe held low
    addr = 13'h0005; rasN = 1'b0; step(1);
    addr = 13'h0006; casN = 1'b0; push(0, 13'h0005, 13'h0006, "R8"); step(1);
    rasN = 1'b1; step(1); addr = 13'h0007; rasN = 1'b0; step(2);
    release_all();
    checkDrained("R8");

    // R9: abandoned refresh and abandoned access
    casN = 1'b0; step(1); casN = 1'b1; step(2);
    rasN = 1'b0; addr = 13'h0100; step(1); rasN = 1'b1; step(2);
    checkDrained("R9");
    doRefresh("R9");
    doAccess(13'h0200, 13'h0300, "R9");
    checkDrained("R9");

    // R5: run the counter past its wrap point
    for (int i = 0; i < ROW_COUNT + 2; i++) doRefresh("R5");
    checkDrained("R5");
    tests++;
    if (expRef != 8) begin
      failed++;
      $display("FAIL R5: bench row tracker=%0d, expected 8", expRef);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule